// File: doc/BRIEF.md
# Multi-Word Flash Program Sequencer

This block carries out one program transaction on a flash array. The transaction may write one word or several. A start strobe supplies the first word address, the word count, the partition select and a program-type select. The block checks the request before it accepts it. If the check fails, the request ends at once with an error and writes nothing. If the check passes, the block takes data words from a program FIFO one at a time. Each word's target address comes from the number of words already taken. An external protection lookup looks at that address and returns a permission bit. The block turns every permitted word into a single-cycle write strobe on the flash write port.

Errors and completion are reported separately. When a word is refused, the error code and the error address are latched and flagged in the next cycle, even though the transaction has not finished. After that the block keeps draining the FIFO until the requested count has been consumed, but it issues no further writes. Completion is flagged only after the last requested word has left the FIFO. While the FIFO is empty the block simply waits. A disable input does not cut short a transaction that is already running. It makes every later request fail.

Top module: `prog_seq_top`

## Requirements
- R1: Right after reset, busy_o, err_o, done_o, fifo_pop_o and wr_en_o are 0, and err_code_o and err_addr_o are 0.
- R2: A request is aborted if the first word address and the last word address, divided by WIN_WORDS (16 by default), differ. One cycle after the start strobe, err_o and done_o are both 1, err_code_o is 2, err_addr_o holds the start address and busy_o is 0. An aborted request pops nothing and writes nothing.
- R3: A request is aborted with err_code_o = 3 if type_en_i bit [type_sel_i] is 0. The window check from R2 takes priority over this check.
- R4: If disable_i is 1 when a request is started, the request is aborted with err_code_o = 1. This check takes priority over both the window check and the type check.
- R5: While the sequencer is busy, wr_addr_o equals the start address plus the number of words already popped. wr_data_o equals fifo_data_i in the same cycle, and wr_part_o holds the partition latched at start.
- R6: While fifo_valid_i is 0, there is no pop, no write and no error, and the transaction stays busy with the word address unchanged.
- R7: A popped word with perm_ok_i = 0 is not written. In the next cycle err_o pulses with err_code_o = 4 and err_addr_o set to that word's address. Only the first refused word is recorded.
- R8: After an error has been recorded, every remaining word is still popped, but wr_en_o stays 0. Writes made before the error are not undone.
- R9: done_o pulses exactly once per transaction. It comes in the cycle after the last requested word is popped, which is the same cycle in which busy_o falls.
- R10: If disable_i rises while a transaction is running, the transaction still writes every permitted word and ends with done_o.
- R11: A start strobe that arrives while busy_o is 1 is ignored. The address, partition and count of the running transaction do not change.
- R12: word_cnt_i holds the number of words minus one, so 0 requests one word and 15 requests sixteen words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| start_addr_i | input | ADDR_W | Address of the first word |
| word_cnt_i | input | CNT_W | Number of words minus one |
| part_i | input | 1 | Partition select, latched at start |
| type_sel_i | input | TYPE_W | Program type select |
| type_en_i | input | NUM_TYPES | Per-type enable bits |
| disable_i | input | 1 | Block-level disable |
| fifo_data_i | input | DATA_W | Program FIFO head word |
| fifo_valid_i | input | 1 | FIFO has a word |
| fifo_pop_o | output | 1 | Consume the FIFO head this cycle |
| perm_ok_i | input | 1 | Permission result for wr_addr_o |
| wr_en_o | output | 1 | Flash write strobe |
| wr_addr_o | output | ADDR_W | Word address for write and permission lookup |
| wr_data_o | output | DATA_W | Write data |
| wr_part_o | output | 1 | Partition of the write |
| busy_o | output | 1 | Transaction running |
| err_o | output | 1 | Error event pulse |
| err_code_o | output | 3 | Last recorded error code |
| err_addr_o | output | ADDR_W | Address of the last recorded error |
| done_o | output | 1 | Completion pulse |

## Verification
The hardest condition to reach is a refused word in the middle of a transaction that is also stalled by FIFO gaps. In that case the error has to appear before completion, the later pops have to continue without writes, and the word address has to survive the stalls. The bench drives a combinational permission model that refuses one chosen address. It inserts gaps into the FIFO valid signal on a fixed cadence. It places the refused address at the first, a middle and the last word of a transaction. A separate sweep covers every start offset across two windows with every count, so that each window-crossing boundary is hit from both sides.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        PE_NONE     = 3'd0,
        PE_DISABLED = 3'd1,
        PE_WINDOW   = 3'd2,
        PE_TYPE     = 3'd3,
        PE_DENIED   = 3'd4
    } prog_err_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic      valid;
        prog_err_e code;
    } verdict_t;

    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prog_start_check.sv
module prog_start_check
    import flash_prog_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned WIN_WORDS = 16,
    parameter int unsigned NUM_TYPES = 2,
    localparam int unsigned TYPE_W   = sel_width(NUM_TYPES)
) (
    input  logic [ADDR_W-1:0]    start_addr_i,
    input  logic [CNT_W-1:0]     word_cnt_i,
    input  logic [TYPE_W-1:0]    type_sel_i,
    input  logic [NUM_TYPES-1:0] type_en_i,
    input  logic                 disabled_i,
    output verdict_t             verdict_o
);
    localparam int unsigned WIN_LG = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 0;

    logic [ADDR_W:0] first_ext;
    logic [ADDR_W:0] last_ext;
    logic            crosses;
    logic            type_ok;

    assign first_ext = {1'b0, start_addr_i};
    assign last_ext  = first_ext + (ADDR_W+1)'(word_cnt_i);
    assign crosses   = (first_ext >> WIN_LG) != (last_ext >> WIN_LG);
    assign type_ok   = (int'(type_sel_i) < NUM_TYPES) && type_en_i[type_sel_i];

    always_comb begin
        verdict_o.valid = 1'b1;
        verdict_o.code  = PE_NONE;
        if (disabled_i) begin
            verdict_o.valid = 1'b0;
            verdict_o.code  = PE_DISABLED;
        end else if (crosses) begin
            verdict_o.valid = 1'b0;
            verdict_o.code  = PE_WINDOW;
        end else if (!type_ok) begin
            verdict_o.valid = 1'b0;
            verdict_o.code  = PE_TYPE;
        end
    end

    initial begin
        AST_WIN_POW2: assert ((WIN_WORDS & (WIN_WORDS - 1)) == 0); // R2
    end

endmodule

// File: rtl/prog_word_track.sv
module prog_word_track #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  last_idx_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              is_last_o
);
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            base_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (load_i) begin
            base_q <= base_i;
            idx_q  <= '0;
            last_q <= last_idx_i;
        end else if (advance_i && !is_last_o) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign cur_addr_o = base_q + ADDR_W'(idx_q);
    assign is_last_o  = (idx_q == last_q);

    AST_ADDR_STEPS: assert property (@(posedge clk_i) disable iff (rst_i)
        advance_i && !is_last_o && !load_i |=> cur_addr_o == $past(cur_addr_o) + 1'b1); // R5

    AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        !advance_i && !load_i |=> $stable(cur_addr_o)); // R6

endmodule

// File: rtl/prog_report.sv
module prog_report
    import flash_prog_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              set_err_i,
    input  prog_err_e         code_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              set_done_i,
    output logic              err_o,
    output prog_err_e         code_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_o  <= 1'b0;
            done_o <= 1'b0;
            code_o <= PE_NONE;
            addr_o <= '0;
        end else begin
            err_o  <= set_err_i;
            done_o <= set_done_i;
            if (set_err_i) begin
                code_o <= code_i;
                addr_o <= addr_i;
            end
        end
    end

    AST_ERR_HAS_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> code_o != PE_NONE); // R7

endmodule

// File: rtl/prog_seq_top.sv
module prog_seq_top
    import flash_prog_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned WIN_WORDS = 16,
    parameter int unsigned NUM_TYPES = 2,
    localparam int unsigned TYPE_W   = sel_width(NUM_TYPES)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    start_addr_i,
    input  logic [CNT_W-1:0]     word_cnt_i,
    input  logic                 part_i,
    input  logic [TYPE_W-1:0]    type_sel_i,
    input  logic [NUM_TYPES-1:0] type_en_i,
    input  logic                 disable_i,
    input  logic [DATA_W-1:0]    fifo_data_i,
    input  logic                 fifo_valid_i,
    output logic                 fifo_pop_o,
    input  logic                 perm_ok_i,
    output logic                 wr_en_o,
    output logic [ADDR_W-1:0]    wr_addr_o,
    output logic [DATA_W-1:0]    wr_data_o,
    output logic                 wr_part_o,
    output logic                 busy_o,
    output logic                 err_o,
    output logic [2:0]           err_code_o,
    output logic [ADDR_W-1:0]    err_addr_o,
    output logic                 done_o
);
    seq_state_e        state_q;
    logic              part_q;
    logic              err_seen_q;
    verdict_t          verdict;
    logic              take;
    logic              abort;
    logic              go;
    logic              pop;
    logic              deny;
    logic              finish;
    logic [ADDR_W-1:0] cur_addr;
    logic              is_last;
    logic              set_err;
    prog_err_e         err_code_in;
    logic [ADDR_W-1:0] err_addr_in;
    prog_err_e         code_q;

    prog_start_check #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .WIN_WORDS (WIN_WORDS),
        .NUM_TYPES (NUM_TYPES)
    ) u_check (
        .start_addr_i (start_addr_i),
        .word_cnt_i   (word_cnt_i),
        .type_sel_i   (type_sel_i),
        .type_en_i    (type_en_i),
        .disabled_i   (disable_i),
        .verdict_o    (verdict)
    );

    assign take   = start_i && (state_q == SQ_IDLE);
    assign abort  = take && !verdict.valid;
    assign go     = take && verdict.valid;
    assign pop    = (state_q == SQ_RUN) && fifo_valid_i;
    assign deny   = pop && !perm_ok_i && !err_seen_q;
    assign finish = pop && is_last;

    prog_word_track #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_track (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (go),
        .base_i     (start_addr_i),
        .last_idx_i (word_cnt_i),
        .advance_i  (pop),
        .cur_addr_o (cur_addr),
        .is_last_o  (is_last)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= SQ_IDLE;
            part_q     <= 1'b0;
            err_seen_q <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: if (go) begin
                    state_q    <= SQ_RUN;
                    part_q     <= part_i;
                    err_seen_q <= 1'b0;
                end
                SQ_RUN: begin
                    if (deny)   err_seen_q <= 1'b1;
                    if (finish) state_q    <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign set_err     = abort || deny;
    assign err_code_in = abort ? verdict.code : PE_DENIED;
    assign err_addr_in = abort ? start_addr_i : cur_addr;

    prog_report #(
        .ADDR_W (ADDR_W)
    ) u_report (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .set_err_i  (set_err),
        .code_i     (err_code_in),
        .addr_i     (err_addr_in),
        .set_done_i (abort || finish),
        .err_o      (err_o),
        .code_o     (code_q),
        .addr_o     (err_addr_o),
        .done_o     (done_o)
    );

    assign err_code_o = code_q;
    assign fifo_pop_o = pop;
    assign wr_en_o    = pop && perm_ok_i && !err_seen_q;
    assign wr_addr_o  = cur_addr;
    assign wr_data_o  = fifo_data_i;
    assign wr_part_o  = part_q;
    assign busy_o     = (state_q == SQ_RUN);

    AST_POP_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
        fifo_pop_o |-> fifo_valid_i); // R6

    AST_WRITE_IS_POP: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_o |-> fifo_pop_o && perm_ok_i); // R7

    AST_NO_WRITE_AFTER_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o && err_o |-> !wr_en_o); // R8

    AST_ABORT_REPORTS: assert property (@(posedge clk_i) disable iff (rst_i)
        abort |=> err_o && done_o && !busy_o); // R2

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !busy_o); // R9

    AST_IDLE_NO_POP: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> !fifo_pop_o && !wr_en_o); // R2

    AST_BUSY_HOLDS_PART: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o && $past(busy_o) |-> $stable(wr_part_o)); // R11

endmodule

// File: tb/prog_seq_top_tb_top.sv
module prog_seq_top_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int WIN = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [AW-1:0] start_addr_i;
    logic [CW-1:0] word_cnt_i;
    logic          part_i;
    logic [0:0]    type_sel_i;
    logic [1:0]    type_en_i;
    logic          disable_i;
    logic [DW-1:0] fifo_data_i;
    logic          fifo_valid_i;
    logic          fifo_pop_o;
    logic          perm_ok_i;
    logic          wr_en_o;
    logic [AW-1:0] wr_addr_o;
    logic [DW-1:0] wr_data_o;
    logic          wr_part_o;
    logic          busy_o;
    logic          err_o;
    logic [2:0]    err_code_o;
    logic [AW-1:0] err_addr_o;
    logic          done_o;

    logic          deny_en;
    logic [AW-1:0] deny_a;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign perm_ok_i = !(deny_en && wr_addr_o == deny_a);

    prog_seq_top dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .word_cnt_i(word_cnt_i), .part_i(part_i), .type_sel_i(type_sel_i),
        .type_en_i(type_en_i), .disable_i(disable_i), .fifo_data_i(fifo_data_i),
        .fifo_valid_i(fifo_valid_i), .fifo_pop_o(fifo_pop_o), .perm_ok_i(perm_ok_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_part_o(wr_part_o), .busy_o(busy_o), .err_o(err_o),
        .err_code_o(err_code_o), .err_addr_o(err_addr_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mkdata(input int s, input int k);
        return DW'(s * 37 + k * 5 + 16'h1234);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // One transaction: s start, n count-1, expected abort code computed here.
    task automatic run_txn(input int s, input int n, input bit part, input bit typ,
                           input logic [1:0] en, input bit dis0, input bit dis_mid,
                           input bit den, input int da, input bit gap, input bit hold);
        int exp_abort;
        int popped = 0;
        int cyc = 0;
        bit err_seen = 0;
        bit prev_deny = 0;
        bit prev_last = 0;
        int prev_addr = 0;
        int lasta = s + n;
        exp_abort = 0;
        if (dis0) exp_abort = 1;
        else if ((s / WIN) != (lasta / WIN)) exp_abort = 2;
        else if (!en[typ]) exp_abort = 3;
        deny_en = den;
        deny_a = AW'(da);
        @(negedge clk);
        start_i = 1; start_addr_i = AW'(s); word_cnt_i = CW'(n); part_i = part;
        type_sel_i = typ; type_en_i = en; disable_i = dis0; fifo_valid_i = 0;
        @(negedge clk);
        start_i = 0;
        if (exp_abort != 0) begin
            chk(err_o && done_o && !busy_o, "R2/R3/R4 abort flags", {err_o, done_o, busy_o}, 6);
            chk(err_code_o == 3'(exp_abort), "R2/R3/R4 abort code", err_code_o, exp_abort);
            chk(err_addr_o == AW'(s), "R2 abort addr", err_addr_o, s);
            fifo_valid_i = 1;
            #1;
            chk(!fifo_pop_o && !wr_en_o, "R2 no pop/write on abort", {fifo_pop_o, wr_en_o}, 0);
            fifo_valid_i = 0;
            disable_i = 0;
            return;
        end
        forever begin
            chk(done_o == prev_last, "R9 done timing", done_o, prev_last);
            chk(err_o == prev_deny, "R7 err timing", err_o, prev_deny);
            if (prev_deny) begin
                chk(err_code_o == 3'd4, "R7 err code", err_code_o, 4);
                chk(err_addr_o == AW'(prev_addr), "R7 err addr", err_addr_o, prev_addr);
            end
            if (prev_last) begin
                chk(!busy_o, "R9 busy falls with done", busy_o, 0);
                break;
            end
            chk(busy_o, "R6/R12 still busy", busy_o, 1);
            if (popped > n) begin
                chk(0, "R12 pop count exceeded", popped, n + 1);
                break;
            end
            cyc++;
            fifo_valid_i = !(gap && (cyc % 3 == 0));
            fifo_data_i = mkdata(s, popped);
            if (dis_mid && cyc == 2) disable_i = 1;
            if (hold) begin
                start_i = 1; start_addr_i = AW'(s + 77); part_i = !part; word_cnt_i = '0;
            end
            #1;
            chk(fifo_pop_o == fifo_valid_i, "R6 pop follows valid", fifo_pop_o, fifo_valid_i);
            chk(wr_addr_o == AW'(s + popped), "R5/R11 word addr", wr_addr_o, s + popped);
            if (fifo_valid_i) begin
                bit dn;
                bit exp_wr;
                dn = den && ((s + popped) % 256 == da);
                exp_wr = !err_seen && !dn;
                chk(wr_en_o == exp_wr, "R7/R8/R10 write strobe", wr_en_o, exp_wr);
                if (wr_en_o) begin
                    chk(wr_data_o == mkdata(s, popped), "R5 write data", wr_data_o, mkdata(s, popped));
                    chk(wr_part_o == part, "R5/R11 partition", wr_part_o, part);
                end
                prev_deny = !err_seen && dn;
                prev_addr = s + popped;
                if (prev_deny) err_seen = 1;
                prev_last = (popped == n);
                popped++;
            end else begin
                chk(!wr_en_o, "R6 no write on stall", wr_en_o, 0);
                prev_deny = 0;
                prev_last = 0;
            end
            @(negedge clk);
        end
        start_i = 0; fifo_valid_i = 0; disable_i = 0; deny_en = 0;
        chk(popped == n + 1, "R12 words consumed", popped, n + 1);
        @(negedge clk);
        chk(!done_o && !err_o, "R9 single done pulse", {done_o, err_o}, 0);
    endtask

    initial begin
        rst = 1; start_i = 0; start_addr_i = '0; word_cnt_i = '0; part_i = 0;
        type_sel_i = '0; type_en_i = 2'b11; disable_i = 0; fifo_data_i = '0;
        fifo_valid_i = 0; deny_en = 0; deny_a = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy_o && !err_o && !done_o && !fifo_pop_o && !wr_en_o, "R1 reset flags",
            {busy_o, err_o, done_o, fifo_pop_o, wr_en_o}, 0);
        chk(err_code_o == 0 && err_addr_o == 0, "R1 reset error regs", err_code_o, 0);
        @(negedge clk);
        rst = 0;

        // R2 R5 R9 R12 sweep: all offsets over two windows, every count
        for (int s = 0; s < 2 * WIN; s++)
            for (int n = 0; n < 16; n++)
                run_txn(s, n, s[0], 0, 2'b11, 0, 0, 0, 0, (s + n) % 2 == 1, 0);
        run_txn(250, 9, 0, 0, 2'b11, 0, 0, 0, 0, 0, 0);   // R2 top-of-space crossing
        run_txn(240, 15, 1, 0, 2'b11, 0, 0, 0, 0, 1, 0);  // R12 full window

        // R3 type enables and window priority
        run_txn(64, 3, 0, 1, 2'b01, 0, 0, 0, 0, 0, 0);
        run_txn(64, 3, 0, 1, 2'b10, 0, 0, 0, 0, 0, 0);
        run_txn(70, 12, 0, 1, 2'b01, 0, 0, 0, 0, 0, 0);

        // R7 R8 denied word at middle, first and last position, with stalls
        run_txn(32, 7, 1, 0, 2'b11, 0, 0, 1, 35, 1, 0);
        run_txn(48, 5, 0, 0, 2'b11, 0, 0, 1, 48, 1, 0);
        run_txn(80, 4, 0, 0, 2'b11, 0, 0, 1, 84, 0, 0);
        run_txn(96, 0, 1, 0, 2'b11, 0, 0, 1, 96, 0, 0);

        // R10 disable mid-run, then R4 priority over window and type
        run_txn(112, 9, 0, 0, 2'b11, 0, 1, 0, 0, 1, 0);
        run_txn(120, 12, 0, 1, 2'b01, 1, 0, 0, 0, 0, 0);
        run_txn(128, 2, 0, 0, 2'b11, 1, 0, 0, 0, 0, 0);
        run_txn(128, 2, 0, 0, 2'b11, 0, 0, 0, 0, 0, 0);

        // R11 start held high during a run with different fields
        run_txn(144, 11, 1, 0, 2'b11, 0, 0, 0, 0, 1, 1);
        run_txn(160, 6, 0, 0, 2'b11, 0, 0, 1, 163, 0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule